// File: doc/BRIEF.md
# CAN Frame Buffer Packer

This block moves a CAN message between its parsed form and the 13-byte image that a controller's transmit and receive buffer holds. The pack side takes an identifier, a length code, four frame flags and up to eight data bytes in one cycle. It then streams the image out one byte per accepted transfer over a valid/ready pair. The unpack side takes a stream of image bytes qualified by a valid strobe. After the thirteenth byte it presents the decoded message together with a one-cycle done pulse.

Inside the image, the identifier is big-endian and left-aligned. An 11-bit identifier sits in two bytes and a 29-bit identifier in four, so the data field starts at a position that depends on the frame format. Bus serialisation, CRC and bit stuffing are handled elsewhere.

Top module: `can_frame_codec`

## Requirements
- R1: Image byte 0 holds the length code in bits 3:0, the self-receive flag in bit 4, the one-shot flag in bit 5, the remote flag in bit 6 and the format flag in bit 7 (1 means extended).
- R2: For a standard frame, the 11-bit identifier shifted left by 5 fills bytes 1 and 2, most significant byte first, and data byte k goes to image byte 3+k.
- R3: For an extended frame, the 29-bit identifier shifted left by 3 fills bytes 1 to 4, most significant byte first, and data byte k goes to image byte 5+k.
- R4: On pack, the identifier is masked to 11 or 29 bits before shifting. Only the first min(length,8) data bytes are placed, and none at all for a remote frame. Every other image byte is zero.
- R5: An accepted start makes tx_valid high from the next cycle. A pack ends after exactly 13 transfers (tx_valid and tx_ready both high), and tx_last marks the 13th. While tx_ready is low, tx_byte and tx_last hold. tx_valid drops after the last transfer.
- R6: A start request while a pack is in progress is ignored: the stream in flight is unchanged and no second pack follows.
- R7: On unpack, the cycle after the 13th valid byte, up_done is high for one cycle and the header flags, raw length and identifier decoded per R1 to R3 are on the outputs.
- R8: On unpack, a length code above 8 raises up_badlen and limits the copied data to 8 bytes, while up_len still reports the raw code.
- R9: On unpack, data bytes at or beyond the copied length, and all data of a remote frame, are output as zero.
- R10: Unpack counts only bytes presented with rx_valid high. Idle cycles neither advance the count nor alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_start | input | 1 | Request to pack the message on the pk_* inputs |
| pk_ident | input | 29 | Identifier (low 11 bits used for standard) |
| pk_len | input | 4 | Length code |
| pk_ext | input | 1 | Extended format |
| pk_remote | input | 1 | Remote frame |
| pk_oneshot | input | 1 | One-shot flag |
| pk_selfrx | input | 1 | Self-receive flag |
| pk_data | input | 64 | Data bytes, byte k in bits 8k+7:8k |
| tx_valid | output | 1 | Image byte available |
| tx_ready | input | 1 | Consumer takes the byte |
| tx_byte | output | 8 | Current image byte |
| tx_last | output | 1 | Current byte is image byte 12 |
| rx_valid | input | 1 | rx_byte carries the next image byte |
| rx_byte | input | 8 | Incoming image byte |
| up_done | output | 1 | One-cycle pulse: decoded message updated |
| up_ident | output | 29 | Decoded identifier |
| up_len | output | 4 | Raw length code |
| up_ext | output | 1 | Extended format |
| up_remote | output | 1 | Remote frame |
| up_oneshot | output | 1 | One-shot flag |
| up_selfrx | output | 1 | Self-receive flag |
| up_badlen | output | 1 | Length code above 8 |
| up_data | output | 64 | Decoded data, zero-filled |

## Verification
The first image byte is due the cycle after the clock edge that accepts pk_start. Each later byte is due the cycle after the edge that sees tx_valid and tx_ready together. The decoded outputs and up_done are due one cycle after the edge that takes the thirteenth valid byte. The bench changes inputs on the falling edge and samples one nanosecond later. That places every comparison exactly one rising edge after the stimulus it depends on, and it recounts tx_last and the idle state at those same points.

// File: rtl/can_codec_pkg.sv
package can_codec_pkg;
   localparam int unsigned LEN_W  = 4;
   localparam int unsigned BYTE_W = 8;

   // Header byte; the packed order sets the bit positions of image byte 0.
   typedef struct packed {
      logic             ext;
      logic             remote;
      logic             oneshot;
      logic             selfrx;
      logic [LEN_W-1:0] len;
   } can_hdr_t;
endpackage

// File: rtl/can_byte_ctr.sv
module can_byte_ctr #(
   parameter int unsigned COUNT = 13,
   localparam int unsigned IDX_W = $clog2(COUNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);
   assign at_last = (idx == IDX_W'(COUNT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (step) begin
         idx <= at_last ? '0 : idx + 1'b1;
      end
   end
endmodule

// File: rtl/can_pack_seq.sv
module can_pack_seq
   import can_codec_pkg::*;
#(
   parameter int unsigned DATA_MAX = 8,
   parameter int unsigned EXT_ID_W = 29,
   parameter int unsigned STD_ID_W = 11,
   localparam int unsigned EXT_BYTES = (EXT_ID_W + 7) / 8,
   localparam int unsigned STD_BYTES = (STD_ID_W + 7) / 8,
   localparam int unsigned IMG_N = 1 + EXT_BYTES + DATA_MAX
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [EXT_ID_W-1:0]        ident,
   input  logic [LEN_W-1:0]           len,
   input  logic                       ext,
   input  logic                       remote,
   input  logic                       oneshot,
   input  logic                       selfrx,
   input  logic [BYTE_W*DATA_MAX-1:0] data,
   output logic                       tx_valid,
   input  logic                       tx_ready,
   output logic [BYTE_W-1:0]          tx_byte,
   output logic                       tx_last
);
   localparam int unsigned EW       = 8 * EXT_BYTES;
   localparam int unsigned SW       = 8 * STD_BYTES;
   localparam int unsigned EXT_SH   = EW - EXT_ID_W;
   localparam int unsigned STD_SH   = SW - STD_ID_W;
   localparam int unsigned EXT_BASE = 1 + EXT_BYTES;
   localparam int unsigned STD_BASE = 1 + STD_BYTES;
   localparam int unsigned IDX_W    = $clog2(IMG_N);

   logic [BYTE_W-1:0] img_d [IMG_N];
   logic [BYTE_W-1:0] img_q [IMG_N];
   logic [EW-1:0]     ext_w;
   logic [SW-1:0]     std_w;
   int                ncopy;
   can_hdr_t          hdr;
   logic              busy;
   logic              accept;
   logic [IDX_W-1:0]  idx;
   logic              at_last;

   assign accept = start && !busy;

   always_comb begin
      hdr   = '{ext: ext, remote: remote, oneshot: oneshot, selfrx: selfrx, len: len};
      ncopy = remote ? 0 : ((int'(len) > int'(DATA_MAX)) ? int'(DATA_MAX) : int'(len));
      ext_w = EW'(ident[EXT_ID_W-1:0]) << EXT_SH;
      std_w = SW'(ident[STD_ID_W-1:0]) << STD_SH;
      for (int i = 0; i < IMG_N; i++) img_d[i] = '0;
      img_d[0] = hdr;
      if (ext) begin
         for (int b = 0; b < EXT_BYTES; b++)
            img_d[1 + b] = ext_w[8 * (EXT_BYTES - 1 - b) +: 8];
         for (int d = 0; d < DATA_MAX; d++)
            if (d < ncopy) img_d[EXT_BASE + d] = data[8 * d +: 8];
      end else begin
         for (int b = 0; b < STD_BYTES; b++)
            img_d[1 + b] = std_w[8 * (STD_BYTES - 1 - b) +: 8];
         for (int d = 0; d < DATA_MAX; d++)
            if (d < ncopy) img_d[STD_BASE + d] = data[8 * d +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         for (int i = 0; i < IMG_N; i++) img_q[i] <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         img_q <= img_d;
      end else if (busy && tx_ready && at_last) begin
         busy <= 1'b0;
      end
   end

   can_byte_ctr #(.COUNT(IMG_N)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .step    (busy && tx_ready),
      .idx     (idx),
      .at_last (at_last)
   );

   assign tx_valid = busy;
   assign tx_byte  = img_q[idx];
   assign tx_last  = busy && at_last;
endmodule

// File: rtl/can_unpack_seq.sv
module can_unpack_seq
   import can_codec_pkg::*;
#(
   parameter int unsigned DATA_MAX = 8,
   parameter int unsigned EXT_ID_W = 29,
   parameter int unsigned STD_ID_W = 11,
   localparam int unsigned EXT_BYTES = (EXT_ID_W + 7) / 8,
   localparam int unsigned STD_BYTES = (STD_ID_W + 7) / 8,
   localparam int unsigned IMG_N = 1 + EXT_BYTES + DATA_MAX
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rx_valid,
   input  logic [BYTE_W-1:0]          rx_byte,
   output logic                       done,
   output logic [EXT_ID_W-1:0]        ident,
   output logic [LEN_W-1:0]           len,
   output logic                       ext,
   output logic                       remote,
   output logic                       oneshot,
   output logic                       selfrx,
   output logic                       badlen,
   output logic [BYTE_W*DATA_MAX-1:0] data
);
   localparam int unsigned EW       = 8 * EXT_BYTES;
   localparam int unsigned SW       = 8 * STD_BYTES;
   localparam int unsigned EXT_SH   = EW - EXT_ID_W;
   localparam int unsigned STD_SH   = SW - STD_ID_W;
   localparam int unsigned EXT_BASE = 1 + EXT_BYTES;
   localparam int unsigned STD_BASE = 1 + STD_BYTES;
   localparam int unsigned IDX_W    = $clog2(IMG_N);

   logic [BYTE_W-1:0]          raw_q [IMG_N];
   logic [BYTE_W-1:0]          view  [IMG_N];
   logic [IDX_W-1:0]           idx;
   logic                       at_last;
   can_hdr_t                   hdr;
   logic [EW-1:0]              ext_w;
   logic [SW-1:0]              std_w;
   int                         ncopy;
   logic [EXT_ID_W-1:0]        dec_ident;
   logic [BYTE_W*DATA_MAX-1:0] dec_data;

   can_byte_ctr #(.COUNT(IMG_N)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (1'b0),
      .step    (rx_valid),
      .idx     (idx),
      .at_last (at_last)
   );

   // Image as it stands once the byte now offered is written.
   always_comb begin
      view      = raw_q;
      view[idx] = rx_byte;
   end

   always_comb begin
      hdr   = can_hdr_t'(view[0]);
      ncopy = hdr.remote ? 0 :
              ((int'(hdr.len) > int'(DATA_MAX)) ? int'(DATA_MAX) : int'(hdr.len));
      for (int b = 0; b < EXT_BYTES; b++) ext_w[8 * (EXT_BYTES - 1 - b) +: 8] = view[1 + b];
      for (int b = 0; b < STD_BYTES; b++) std_w[8 * (STD_BYTES - 1 - b) +: 8] = view[1 + b];
      dec_ident = hdr.ext ? EXT_ID_W'(ext_w >> EXT_SH) : EXT_ID_W'(std_w >> STD_SH);
      dec_data  = '0;
      for (int d = 0; d < DATA_MAX; d++)
         if (d < ncopy)
            dec_data[8 * d +: 8] = hdr.ext ? view[EXT_BASE + d] : view[STD_BASE + d];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < IMG_N; i++) raw_q[i] <= '0;
         done    <= 1'b0;
         ident   <= '0;
         len     <= '0;
         ext     <= 1'b0;
         remote  <= 1'b0;
         oneshot <= 1'b0;
         selfrx  <= 1'b0;
         badlen  <= 1'b0;
         data    <= '0;
      end else begin
         done <= rx_valid && at_last;
         if (rx_valid) raw_q[idx] <= rx_byte;
         if (rx_valid && at_last) begin
            ident   <= dec_ident;
            len     <= hdr.len;
            ext     <= hdr.ext;
            remote  <= hdr.remote;
            oneshot <= hdr.oneshot;
            selfrx  <= hdr.selfrx;
            badlen  <= int'(hdr.len) > int'(DATA_MAX);
            data    <= dec_data;
         end
      end
   end
endmodule

// File: rtl/can_frame_codec.sv
module can_frame_codec
   import can_codec_pkg::*;
#(
   parameter int unsigned DATA_MAX = 8,
   parameter int unsigned EXT_ID_W = 29,
   parameter int unsigned STD_ID_W = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pk_start,
   input  logic [EXT_ID_W-1:0]        pk_ident,
   input  logic [LEN_W-1:0]           pk_len,
   input  logic                       pk_ext,
   input  logic                       pk_remote,
   input  logic                       pk_oneshot,
   input  logic                       pk_selfrx,
   input  logic [BYTE_W*DATA_MAX-1:0] pk_data,
   output logic                       tx_valid,
   input  logic                       tx_ready,
   output logic [BYTE_W-1:0]          tx_byte,
   output logic                       tx_last,
   input  logic                       rx_valid,
   input  logic [BYTE_W-1:0]          rx_byte,
   output logic                       up_done,
   output logic [EXT_ID_W-1:0]        up_ident,
   output logic [LEN_W-1:0]           up_len,
   output logic                       up_ext,
   output logic                       up_remote,
   output logic                       up_oneshot,
   output logic                       up_selfrx,
   output logic                       up_badlen,
   output logic [BYTE_W*DATA_MAX-1:0] up_data
);
   generate
      if (STD_ID_W >= EXT_ID_W) begin : g_bad_id
         $error("standard identifier must be narrower than extended");
      end
      if (DATA_MAX < 1 || DATA_MAX >= (1 << LEN_W)) begin : g_bad_data
         $error("DATA_MAX must fit below the length code range");
      end
   endgenerate

   can_pack_seq #(
      .DATA_MAX (DATA_MAX),
      .EXT_ID_W (EXT_ID_W),
      .STD_ID_W (STD_ID_W)
   ) pack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (pk_start),
      .ident    (pk_ident),
      .len      (pk_len),
      .ext      (pk_ext),
      .remote   (pk_remote),
      .oneshot  (pk_oneshot),
      .selfrx   (pk_selfrx),
      .data     (pk_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .tx_byte  (tx_byte),
      .tx_last  (tx_last)
   );

   can_unpack_seq #(
      .DATA_MAX (DATA_MAX),
      .EXT_ID_W (EXT_ID_W),
      .STD_ID_W (STD_ID_W)
   ) unpack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .done     (up_done),
      .ident    (up_ident),
      .len      (up_len),
      .ext      (up_ext),
      .remote   (up_remote),
      .oneshot  (up_oneshot),
      .selfrx   (up_selfrx),
      .badlen   (up_badlen),
      .data     (up_data)
   );
endmodule

// File: rtl/can_frame_codec_chk.sv
module can_frame_codec_chk #(
   parameter int unsigned DATA_MAX = 8,
   parameter int unsigned EXT_ID_W = 29,
   parameter int unsigned STD_ID_W = 11
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tx_valid,
   input logic                  tx_ready,
   input logic [7:0]            tx_byte,
   input logic                  tx_last,
   input logic                  rx_valid,
   input logic                  up_done,
   input logic [EXT_ID_W-1:0]   up_ident,
   input logic [3:0]            up_len,
   input logic                  up_ext,
   input logic                  up_remote,
   input logic                  up_badlen,
   input logic [8*DATA_MAX-1:0] up_data
);
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

   assert_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   assert_no_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !(tx_ready && tx_last) |=> tx_valid);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      up_done |=> !up_done);

   assert_std_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
      up_done && !up_ext |-> (up_ident >> STD_ID_W) == '0);

   assert_badlen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      up_done && up_badlen |-> int'(up_len) > int'(DATA_MAX));

   assert_remote_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      up_done && up_remote |-> up_data == '0);

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !up_done);
endmodule

bind can_frame_codec can_frame_codec_chk #(
   .DATA_MAX (DATA_MAX),
   .EXT_ID_W (EXT_ID_W),
   .STD_ID_W (STD_ID_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_byte   (tx_byte),
   .tx_last   (tx_last),
   .rx_valid  (rx_valid),
   .up_done   (up_done),
   .up_ident  (up_ident),
   .up_len    (up_len),
   .up_ext    (up_ext),
   .up_remote (up_remote),
   .up_badlen (up_badlen),
   .up_data   (up_data)
);

// File: tb/can_frame_codec_tb_top.sv
module can_frame_codec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pk_start = 1'b0;
   logic [28:0] pk_ident = '0;
   logic [3:0]  pk_len = '0;
   logic        pk_ext = 1'b0, pk_remote = 1'b0, pk_oneshot = 1'b0, pk_selfrx = 1'b0;
   logic [63:0] pk_data = '0;
   logic        tx_valid, tx_last;
   logic        tx_ready = 1'b0;
   logic [7:0]  tx_byte;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        up_done, up_ext, up_remote, up_oneshot, up_selfrx, up_badlen;
   logic [28:0] up_ident;
   logic [3:0]  up_len;
   logic [63:0] up_data;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   can_frame_codec dut_i (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input logic [103:0] act, input logic [103:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [103:0] ref_image(logic [28:0] id, logic [3:0] len, bit ext,
                                              bit rem, bit ss, bit sr, logic [63:0] d);
      logic [103:0] r = '0;
      logic [31:0]  v;
      int n, base;
      r[7:0] = {ext, rem, ss, sr, len};
      n = rem ? 0 : (len > 8 ? 8 : int'(len));
      if (ext) begin
         v = {id, 3'b000};
         r[15:8] = v[31:24]; r[23:16] = v[23:16]; r[31:24] = v[15:8]; r[39:32] = v[7:0];
         base = 5;
      end else begin
         v = {16'h0, id[10:0], 5'b00000};
         r[15:8] = v[15:8]; r[23:16] = v[7:0];
         base = 3;
      end
      for (int k = 0; k < n; k++) r[8*(base+k) +: 8] = d[8*k +: 8];
      return r;
   endfunction

   task automatic do_pack(input logic [28:0] id, input logic [3:0] len, input bit ext,
                          input bit rem, input bit ss, input bit sr, input logic [63:0] d,
                          input bit interrupt, output logic [103:0] got);
      int cnt = 0;
      int guard = 0;
      bit last_ok = 1'b1;
      got = '0;
      @(negedge clk);
      pk_ident = id; pk_len = len; pk_ext = ext; pk_remote = rem;
      pk_oneshot = ss; pk_selfrx = sr; pk_data = d; pk_start = 1'b1;
      @(negedge clk);
      pk_start = 1'b0;
      #1 check(tx_valid == 1'b1, "R5", "tx_valid after start", 104'(tx_valid), 104'(1));
      while (cnt < 13 && guard < 200) begin
         guard++;
         tx_ready = ($urandom % 4) != 0;
         if (interrupt && cnt == 5) begin
            pk_start = 1'b1; pk_ident = ~id; pk_ext = ~ext; pk_data = ~d;
         end else begin
            pk_start = 1'b0;
         end
         #1;
         if (tx_valid && tx_ready) begin
            got[8*cnt +: 8] = tx_byte;
            if (tx_last != (cnt == 12)) last_ok = 1'b0;
            cnt++;
         end
         @(negedge clk);
      end
      tx_ready = 1'b0;
      pk_start = 1'b0;
      check(last_ok && cnt == 13, "R5", "13 transfers, tx_last on the 13th", 104'(cnt), 104'(13));
      #1 check(tx_valid == 1'b0, interrupt ? "R6" : "R5", "idle after last byte",
               104'(tx_valid), 104'(0));
   endtask

   task automatic do_unpack(input logic [103:0] img);
      bit early = 1'b0;
      logic [103:0] b0;
      logic [3:0]   len;
      logic [28:0]  id;
      logic [63:0]  dat;
      int n, base;
      for (int i = 0; i < 13; i++) begin
         @(negedge clk);
         while (($urandom % 3) == 0) begin
            rx_valid = 1'b0; rx_byte = 8'($urandom);
            @(negedge clk);
            #1 if (up_done) early = 1'b1;
         end
         rx_valid = 1'b1; rx_byte = img[8*i +: 8];
         #1 if (up_done) early = 1'b1;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_byte = 8'($urandom);
      check(!early, "R10", "no done before 13th valid byte", 104'(early), 104'(0));
      #1;
      b0  = img;
      len = b0[3:0];
      if (b0[7]) id = 29'({img[15:8], img[23:16], img[31:24], img[39:32]} >> 3);
      else       id = 29'({img[15:8], img[23:16]} >> 5);
      n    = b0[6] ? 0 : (len > 8 ? 8 : int'(len));
      base = b0[7] ? 5 : 3;
      dat  = '0;
      for (int k = 0; k < n; k++) dat[8*k +: 8] = img[8*(base+k) +: 8];
      check(up_done == 1'b1, "R7", "done after 13th byte", 104'(up_done), 104'(1));
      check({up_ext, up_remote, up_oneshot, up_selfrx, up_len} == img[7:0], "R7",
            "header fields", 104'({up_ext, up_remote, up_oneshot, up_selfrx, up_len}),
            104'(img[7:0]));
      check(up_ident == id, "R7", "identifier", 104'(up_ident), 104'(id));
      check(up_badlen == (len > 8), "R8", "length flag", 104'(up_badlen), 104'(len > 8));
      check(up_data == dat, "R9", "data zero-filled", 104'(up_data), 104'(dat));
      @(negedge clk);
      #1 check(up_done == 1'b0, "R7", "done one cycle", 104'(up_done), 104'(0));
   endtask

   task automatic round(input logic [28:0] id, input logic [3:0] len, input bit ext,
                        input bit rem, input bit ss, input bit sr, input logic [63:0] d,
                        input bit interrupt);
      logic [103:0] got, exp;
      exp = ref_image(id, len, ext, rem, ss, sr, d);
      do_pack(id, len, ext, rem, ss, sr, d, interrupt, got);
      check(got[7:0] == exp[7:0], "R1", "header byte", got, exp);
      check(got[103:8] == exp[103:8], ext ? "R3" : "R2", "identifier and data bytes", got, exp);
      if (rem || len > 8 || id[28:11] != 0)
         check(got == exp, "R4", "masking and unused bytes zero", got, exp);
      do_unpack(got);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      #1 check(tx_valid == 0 && up_done == 0 && up_ident == 0, "R5", "reset state",
               104'({tx_valid, up_done, up_ident}), 104'(0));
      rst_n = 1'b1;
      // Directed corner cases.
      round(29'h1FFF_F7FF, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 64'h8877_6655_4433_2211, 1'b0);
      round(29'h1234_5678, 4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 64'hFFEE_DDCC_BBAA_9988, 1'b0);
      round(29'h1ABC_DEF1, 4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567, 1'b0);
      round(29'h0000_0555, 4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0102_0304_0506_0708, 1'b0);
      round(29'h0000_0123, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      round(29'h0ACE_1357, 4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 1'b1);
      round(29'h0000_07AA, 4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 64'h5555_6666_7777_8888, 1'b1);
      // Unpack of raw images: oversized length and remote frames with junk data.
      do_unpack({64'hA1A2_A3A4_A5A6_A7A8, 32'h9ABC_DEF7, 8'hFF});
      do_unpack({64'hB1B2_B3B4_B5B6_B7B8, 32'h1357_9BDF, 8'h4B});
      do_unpack({64'hC1C2_C3C4_C5C6_C7C8, 32'h2468_ACE0, 8'h6F});
      // Random frames through pack and unpack.
      for (int t = 0; t < 40; t++)
         round(29'($urandom), 4'($urandom), 1'($urandom), 1'(($urandom % 5) == 0),
               1'($urandom), 1'($urandom), {$urandom, $urandom}, 1'(($urandom % 6) == 0));
      // Random raw images straight into unpack.
      for (int t = 0; t < 20; t++)
         do_unpack({$urandom, $urandom, $urandom, 8'($urandom)});
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule